// File: doc/BRIEF.md
# Two-Bank Hotspot Cartridge Mapper

This block sits on the cartridge side of an 8-bit console whose processor drives only 13 address lines, so every logical address is seen modulo 8 KB. It holds an 8 KB program image made of two 4 KB banks. Only one bank is visible at a time, through a single 4 KB window that the cartridge claims whenever address line 12 is high. When line 12 is low the access belongs to other parts of the system, and the mapper stays off the data bus.

The visible bank is not chosen by writing a register. Reading one of two reserved offsets near the top of the window changes it: one offset picks the lower bank and the next offset up picks the upper bank. Both banks share the window, so after a switch the program goes on at the same window offset in the other bank. Reset selects the upper bank, because the start-up vectors sit in its last four bytes.

The image is loaded through a valid/ready byte stream. The stream is open only while the mapper is held in reset. `load_ready` is high exactly when `rst_n` is low, and a byte is stored on a rising clock edge where `load_valid` and `load_ready` are both high. Outside reset the ready line is low, so offered bytes stay pending and are never taken.

Top module: `hotspot_mapper`

## Requirements
- R1: Only the 13 address bits reach the block. Logical addresses that agree in bits 12..0, such as $1000, $3000, $D000 and $F000, return the same byte under the same bank.
- R2: With the default combinational read (REG_OUT = 0), `rd_oe` is high in the same cycle exactly when `cpu_rd` is high and `cpu_addr[12]` is 1. While `rd_oe` is low, `rd_data` is zero.
- R3: A window read at offset `cpu_addr[11:0]` returns image byte `bank*4096 + offset`. Image bytes 0..4095 form bank 0 and bytes 4096..8191 form bank 1.
- R4: A window read at offset $FF8 makes bank 0 visible from the next cycle on.
- R5: A window read at offset $FF9 makes bank 1 visible from the next cycle on.
- R6: A read of either hotspot offset itself returns the byte from the bank that was visible before that read.
- R7: After reset, bank 1 is visible, so offsets $FFC..$FFF return image bytes 8188..8191.
- R8: The bank stays the same after any read at an offset other than $FF8 or $FF9, after any cycle where `cpu_rd` is low, and after any hotspot offset presented with `cpu_addr[12]` at 0. Reading the same hotspot again leaves the bank as it is.
- R9: `load_ready` is high only while `rst_n` is low. A byte offered while reset is not asserted is not stored, and the ROM keeps its earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also opens the load stream |
| cpu_addr | input | 13 | Processor address, bits 12..0 |
| cpu_rd | input | 1 | Read strobe |
| load_valid | input | 1 | Load stream: byte offered |
| load_ready | output | 1 | Load stream: byte accepted (high only in reset) |
| load_addr | input | 13 | Load stream: image byte index |
| load_data | input | 8 | Load stream: image byte |
| rd_data | output | 8 | Read data to the processor bus |
| rd_oe | output | 1 | Output enable for `rd_data` |

## Verification
The hardest case to reach is the cycle in which a hotspot read happens. In that one cycle the byte must still come from the old bank, while the bank register must already hold the new choice at the next edge. The stimulus table puts hotspot reads straight after reads in the opposite bank and follows each one with a read at an ordinary offset, so the cycle before and the cycle after the switch are both checked. Further vectors present hotspot offsets through high mirrors, with line 12 cleared, or with the strobe low, to show that only genuine window reads move the bank.

// File: rtl/hotspot_mapper_pkg.sv
package hotspot_mapper_pkg;

  typedef enum logic {
    BANK_LO = 1'b0,
    BANK_HI = 1'b1
  } bank_t;

  // hotspots counted down from the last window offset
  localparam int HOT_LO_FROM_TOP = 7;
  localparam int HOT_HI_FROM_TOP = 6;

endpackage

// File: rtl/hotspot_addr_decode.sv
module hotspot_addr_decode #(
  parameter int OFS_W = 12
) (
  input  logic [OFS_W:0]   addr,
  input  logic             rd,
  output logic             win_rd,
  output logic [OFS_W-1:0] offset,
  output logic             hit_lo,
  output logic             hit_hi
);
  import hotspot_mapper_pkg::*;

  localparam logic [OFS_W-1:0] TOP_OFS = {OFS_W{1'b1}};
  localparam logic [OFS_W-1:0] HOT_LO  = TOP_OFS - OFS_W'(HOT_LO_FROM_TOP);
  localparam logic [OFS_W-1:0] HOT_HI  = TOP_OFS - OFS_W'(HOT_HI_FROM_TOP);

  always_comb begin
    win_rd = rd && addr[OFS_W];
    offset = addr[OFS_W-1:0];
    hit_lo = win_rd && (offset == HOT_LO);
    hit_hi = win_rd && (offset == HOT_HI);
  end

endmodule

// File: rtl/hotspot_bank_reg.sv
module hotspot_bank_reg (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hit_lo,
  input  logic                      hit_hi,
  output hotspot_mapper_pkg::bank_t bank
);
  import hotspot_mapper_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bank <= BANK_HI;
    else if (hit_lo) bank <= BANK_LO;
    else if (hit_hi) bank <= BANK_HI;
  end

  AST_LO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lo |=> (bank == BANK_LO)); // R4

  AST_HI_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_hi |=> (bank == BANK_HI)); // R5

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_lo || hit_hi) |=> $stable(bank)); // R8

endmodule

// File: rtl/hotspot_rom_store.sv
module hotspot_rom_store #(
  parameter int OFS_W   = 12,
  parameter int DATA_W  = 8,
  parameter bit REG_OUT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W:0]    wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [OFS_W:0]    rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);
  localparam int DEPTH = 2 ** (OFS_W + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_comb rd_word = rd_en ? mem[rd_idx] : '0;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_data <= '0;
          rd_oe   <= 1'b0;
        end else begin
          rd_data <= rd_word;
          rd_oe   <= rd_en;
        end
      end
    end else begin : g_comb
      always_comb begin
        rd_data = rd_word;
        rd_oe   = rd_en;
      end
    end
  endgenerate

endmodule

// File: rtl/hotspot_mapper.sv
module hotspot_mapper #(
  parameter int OFS_W   = 12,
  parameter int DATA_W  = 8,
  parameter bit REG_OUT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFS_W:0]    cpu_addr,
  input  logic              cpu_rd,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [OFS_W:0]    load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);
  import hotspot_mapper_pkg::*;

  logic             win_rd;
  logic [OFS_W-1:0] offset;
  logic             hit_lo;
  logic             hit_hi;
  bank_t            bank;
  logic             load_beat;

  always_comb begin
    load_ready = !rst_n;
    load_beat  = load_valid && load_ready;
  end

  hotspot_addr_decode #(.OFS_W(OFS_W)) u_decode (
    .addr   (cpu_addr),
    .rd     (cpu_rd),
    .win_rd (win_rd),
    .offset (offset),
    .hit_lo (hit_lo),
    .hit_hi (hit_hi)
  );

  hotspot_bank_reg u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_lo (hit_lo),
    .hit_hi (hit_hi),
    .bank   (bank)
  );

  hotspot_rom_store #(
    .OFS_W   (OFS_W),
    .DATA_W  (DATA_W),
    .REG_OUT (REG_OUT)
  ) u_rom (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (load_beat),
    .wr_idx  (load_addr),
    .wr_data (load_data),
    .rd_en   (win_rd),
    .rd_idx  ({bank, offset}),
    .rd_data (rd_data),
    .rd_oe   (rd_oe)
  );

  generate
    if (!REG_OUT) begin : g_chk_comb
      AST_OFF_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd && cpu_addr[OFS_W]) |-> (!rd_oe && rd_data == '0)); // R2
    end
  endgenerate

endmodule

// File: tb/hotspot_mapper_bench.sv
module hotspot_mapper_bench;

  localparam int NVEC = 18;

  // {rd, 16-bit logical address}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 16'hF000}, {1'b1, 16'hFFFC}, {1'b1, 16'hFFFD},
    {1'b1, 16'h1FF8}, {1'b1, 16'h1FF8}, {1'b1, 16'hD100},
    {1'b1, 16'h3FF9}, {1'b1, 16'h5100}, {1'b1, 16'h0FF8},
    {1'b0, 16'h1FF8}, {1'b1, 16'h7100}, {1'b1, 16'h1FF7},
    {1'b1, 16'h1FFA}, {1'b1, 16'h1100}, {1'b1, 16'h9FF8},
    {1'b1, 16'h1234}, {1'b1, 16'hBFF9}, {1'b1, 16'hB123}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [12:0] load_addr = '0;
  logic [7:0]  load_data = '0;
  logic [7:0]  rd_data;
  logic        rd_oe;

  int checks = 0;
  int errors = 0;
  int mbank  = 1;

  always #4 clk = ~clk;

  hotspot_mapper u_hotspot_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .load_valid(load_valid), .load_ready(load_ready),
    .load_addr(load_addr), .load_data(load_data),
    .rd_data(rd_data), .rd_oe(rd_oe)
  );

  function automatic logic [7:0] img(int idx);
    return 8'((idx * 13) ^ (idx >> 5) ^ ((idx >> 12) * 8'h5A));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one read: drive after falling edge, sample before rising edge, update model
  task automatic rd_cycle(logic rd, logic [15:0] la, string req, output logic [7:0] got);
    logic [7:0] exp_d;
    logic       exp_oe;
    @(negedge clk);
    cpu_rd   = rd;
    cpu_addr = la[12:0];
    #2;
    exp_oe = rd && la[12];
    exp_d  = exp_oe ? img(mbank * 4096 + int'(la[11:0])) : 8'h00;
    check({req, " oe"}, rd_oe, exp_oe);
    check({req, " data"}, rd_data, exp_d);
    got = rd_data;
    if (exp_oe && la[11:0] == 12'hFF8) mbank = 0;
    if (exp_oe && la[11:0] == 12'hFF9) mbank = 1;
  endtask

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] g, g2;
    string tag;
    // load image while in reset (R9)
    #1;
    check("R9 ready in reset", load_ready, 1);
    for (int i = 0; i < 8192; i++) begin
      @(negedge clk);
      load_valid = 1'b1;
      load_addr  = 13'(i);
      load_data  = img(i);
    end
    @(negedge clk);
    load_valid = 1'b0;
    rst_n = 1'b1;
    #1;
    check("R9 ready after reset", load_ready, 0);
    check("R2 reset state oe", rd_oe, 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] la;
      la = VEC[v][15:0];
      if (!(VEC[v][16] && la[12]))         tag = "R2/R8";
      else if (la[11:0] == 12'hFF8)        tag = "R4/R6";
      else if (la[11:0] == 12'hFF9)        tag = "R5/R6";
      else                                 tag = "R3";
      rd_cycle(VEC[v][16], la, tag, g);
    end

    // R1: mirrored addresses give the same byte
    rd_cycle(1'b1, 16'hF010, "R1", g);
    rd_cycle(1'b1, 16'h3010, "R1", g2);
    check("R1 mirror match", g2, g);

    // R6: hotspot read returns old bank byte (bank 1 -> 0)
    rd_cycle(1'b1, 16'h1FF9, "R5", g);
    rd_cycle(1'b1, 16'h1FF8, "R6", g);
    check("R6 old bank at FF8", g, img(4096 + 12'hFF8));
    rd_cycle(1'b1, 16'h1FF8, "R8 repeat", g);
    check("R8 repeat stays bank0", g, img(12'hFF8));

    // R9: load outside reset ignored
    @(negedge clk);
    load_valid = 1'b1;
    load_addr  = 13'h0000;
    load_data  = ~img(0);
    @(negedge clk);
    load_valid = 1'b0;
    rd_cycle(1'b1, 16'h1000, "R9 ignored load", g);
    check("R9 rom unchanged", g, img(0));

    // R7: re-reset gives bank 1 and vectors
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mbank = 1;
    for (int k = 12; k < 16; k++) begin
      rd_cycle(1'b1, 16'hFFF0 + 16'(k), "R7", g);
      check("R7 vector", g, img(8176 + k));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule